// File: doc/BRIEF.md
# Write-Triggered Interrupt Request Decoder

This block sits on the memory-write side of an interrupt controller. It lets a device raise an interrupt by storing a small number into one fixed register instead of driving a wire. Each accepted write turns the low five bits of its data into one bit of a 24-line interrupt request register (IRR). Numbers that are out of range, numbers reserved for system lines, writes to lines set up as level-triggered, and all writes while the message capability is off are dropped without any effect.

Pending requests leave the block one at a time. The lowest-numbered pending line is shown on a vector output together with a request strobe. When the consumer returns an acknowledge, that bit clears. The capability flag is registered from a requested value and the extended-controller enable, so software can never see it set while the extended controller is off.

Top module: `msg_irq_decoder`

## Requirements
- R1: A write is decoded only when `wr_addr` equals the register base plus 0x20, which is 0xFEC0_0020 by default. A write to any other address changes nothing.
- R2: `wr_data[4:0]` is an unsigned binary line number and sets IRR bit n for value n. Bits [31:5] have no effect.
- R3: Line numbers 24 to 31 set no IRR bit.
- R4: Line numbers 0, 2, 8 and 13 set no IRR bit.
- R5: A write is accepted only while `msg_cap` is 1.
- R6: `msg_cap` is the registered AND of `cap_req` and `xapic_en`, and is valid one cycle after they change. It is never 1 while `xapic_en` was 0 on the previous cycle.
- R7: A write sets bit n only when `edge_mask[n]` is 1 (edge-triggered). A value of 0 (level-triggered) means the write is ignored.
- R8: `dlv_req` is 1 exactly when any IRR bit is set, and `dlv_vec` then gives the lowest set bit number.
- R9: A cycle with `dlv_req` and `dlv_ack` both high clears IRR bit `dlv_vec` at that clock edge.
- R10: A write to a line that is already pending leaves it set, and a single acknowledge then clears it.
- R11: When a set and an acknowledge-clear of the same bit fall in the same cycle, the set wins and the bit stays 1.
- R12: A synchronous active-low reset clears the whole IRR and `msg_cap`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | A write is present this cycle |
| wr_addr | input | 32 | Write address |
| wr_data | input | 32 | Write data; the low 5 bits hold the line number |
| xapic_en | input | 1 | Extended interrupt controller enable |
| cap_req | input | 1 | Requested value of the message capability flag |
| edge_mask | input | 24 | Per-line trigger mode, 1 = edge |
| msg_cap | output | 1 | Effective message capability flag |
| irr | output | 24 | Interrupt request register |
| dlv_req | output | 1 | A request is pending for delivery |
| dlv_vec | output | 5 | Lowest pending line number |
| dlv_ack | input | 1 | Delivery acknowledge |

## Verification
The bench writes all 32 data values under three trigger-mode patterns, with junk in the upper data bits. A decoder that let values 24–31 alias onto low lines, or that missed one of the four reserved lines, would show a stray IRR bit. The same happens if it ignored the trigger mode or read the upper data bits. Draining several pending lines checks the lowest-first order, which a reversed priority encoder breaks. Set-versus-clear collisions on the same bit catch a design where the clear wins, and double writes catch one that toggles instead of merging. Writes with the capability off, or with the extended enable low, must leave the IRR untouched.

// File: rtl/msgirq_pkg.sv
package msgirq_pkg;
    localparam logic [31:0] DEF_CTRL_BASE   = 32'hFEC0_0000;
    localparam logic [31:0] ASSERT_REG_OFS  = 32'h0000_0020;
    // lines 0, 2, 8, 13 are held for system sources
    localparam logic [23:0] DEF_RESERVED    = 24'h00_2105;
endpackage

// File: rtl/msgirq_addr_match.sv
module msgirq_addr_match #(
    parameter int          ADDR_W = 32,
    parameter logic [ADDR_W-1:0] TARGET = '0
) (
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              hit
);
    always_comb hit = wr_valid && (wr_addr == TARGET);
endmodule

// File: rtl/msgirq_vec_decode.sv
module msgirq_vec_decode #(
    parameter int                  DATA_W   = 32,
    parameter int                  NUM_IRQ  = 24,
    parameter int                  FIELD_W  = 5,
    parameter logic [NUM_IRQ-1:0]  RESERVED = '0
) (
    input  logic [DATA_W-1:0]  data,
    output logic [NUM_IRQ-1:0] onehot
);
    logic [FIELD_W-1:0] num;
    assign num = data[FIELD_W-1:0];

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
        if (RESERVED[i]) begin : g_res
            assign onehot[i] = 1'b0;
        end else begin : g_ok
            assign onehot[i] = (num == FIELD_W'(i));
        end
    end
endmodule

// File: rtl/msgirq_pick_lowest.sv
module msgirq_pick_lowest #(
    parameter int N = 24,
    parameter int W = 5
) (
    input  logic [N-1:0] pend,
    output logic         any,
    output logic [W-1:0] idx
);
    always_comb begin
        any = |pend;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i]) idx = W'(i);
        end
    end
endmodule

// File: rtl/msg_irq_decoder.sv
module msg_irq_decoder #(
    parameter int                  ADDR_W    = 32,
    parameter int                  DATA_W    = 32,
    parameter int                  NUM_IRQ   = 24,
    parameter int                  FIELD_W   = 5,
    parameter logic [ADDR_W-1:0]   CTRL_BASE = msgirq_pkg::DEF_CTRL_BASE,
    parameter logic [NUM_IRQ-1:0]  RESERVED  = msgirq_pkg::DEF_RESERVED
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_valid,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               xapic_en,
    input  logic               cap_req,
    input  logic [NUM_IRQ-1:0] edge_mask,
    output logic               msg_cap,
    output logic [NUM_IRQ-1:0] irr,
    output logic               dlv_req,
    output logic [FIELD_W-1:0] dlv_vec,
    input  logic               dlv_ack
);
    localparam logic [ADDR_W-1:0] TARGET = CTRL_BASE + ADDR_W'(msgirq_pkg::ASSERT_REG_OFS);

    typedef struct packed {
        logic [NUM_IRQ-1:0] irr;
        logic               cap;
    } state_t;

    state_t st_d, st_q;

    logic               hit;
    logic [NUM_IRQ-1:0] line_onehot;
    logic [NUM_IRQ-1:0] set_vec;
    logic [NUM_IRQ-1:0] clr_vec;

    msgirq_addr_match #(.ADDR_W(ADDR_W), .TARGET(TARGET)) u_match (
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .hit      (hit)
    );

    msgirq_vec_decode #(
        .DATA_W(DATA_W), .NUM_IRQ(NUM_IRQ), .FIELD_W(FIELD_W), .RESERVED(RESERVED)
    ) u_dec (
        .data   (wr_data),
        .onehot (line_onehot)
    );

    msgirq_pick_lowest #(.N(NUM_IRQ), .W(FIELD_W)) u_pick (
        .pend (st_q.irr),
        .any  (dlv_req),
        .idx  (dlv_vec)
    );

    always_comb begin
        st_d     = st_q;
        st_d.cap = cap_req & xapic_en;
        for (int i = 0; i < NUM_IRQ; i++) begin
            clr_vec[i] = dlv_req && dlv_ack && (dlv_vec == FIELD_W'(i));
        end
        set_vec  = (hit && st_q.cap) ? (line_onehot & edge_mask) : '0;
        // set is applied after clear so a colliding set survives
        st_d.irr = (st_q.irr & ~clr_vec) | set_vec;
        if (!rst_n) st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign msg_cap = st_q.cap;
    assign irr     = st_q.irr;
endmodule

// File: rtl/msgirq_checker.sv
module msgirq_checker #(
    parameter int                 NUM_IRQ  = 24,
    parameter int                 FIELD_W  = 5,
    parameter logic [NUM_IRQ-1:0] RESERVED = '0
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_valid,
    input logic               xapic_en,
    input logic [NUM_IRQ-1:0] edge_mask,
    input logic               msg_cap,
    input logic [NUM_IRQ-1:0] irr,
    input logic               dlv_req,
    input logic [FIELD_W-1:0] dlv_vec,
    input logic               dlv_ack
);
    logic [NUM_IRQ-1:0] below;
    always_comb below = (NUM_IRQ'(1) << dlv_vec) - NUM_IRQ'(1);

    p_reset_clears_r12: assert property (@(posedge clk)
        !rst_n |=> (irr == '0 && !msg_cap));

    p_reserved_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (irr & RESERVED) == '0);

    p_level_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irr & ~$past(irr) & ~$past(edge_mask)) == '0);

    p_cap_gates_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !msg_cap |=> (irr & ~$past(irr)) == '0);

    p_cap_needs_ext_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !xapic_en |=> !msg_cap);

    p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_req && dlv_ack && !wr_valid) |=> !irr[$past(dlv_vec)]);

    p_lowest_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_req |-> (irr[dlv_vec] && (irr & below) == '0));
endmodule

bind msg_irq_decoder msgirq_checker #(
    .NUM_IRQ(NUM_IRQ), .FIELD_W(FIELD_W), .RESERVED(RESERVED)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (wr_valid),
    .xapic_en  (xapic_en),
    .edge_mask (edge_mask),
    .msg_cap   (msg_cap),
    .irr       (irr),
    .dlv_req   (dlv_req),
    .dlv_vec   (dlv_vec),
    .dlv_ack   (dlv_ack)
);

// File: tb/tb_msg_irq_decoder.sv
module tb_msg_irq_decoder;
    localparam logic [31:0] TGT = 32'hFEC0_0020;
    localparam logic [23:0] RES = 24'h00_2105;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        xapic_en = 1'b0;
    logic        cap_req = 1'b0;
    logic [23:0] edge_mask = '1;
    logic        msg_cap;
    logic [23:0] irr;
    logic        dlv_req;
    logic [4:0]  dlv_vec;
    logic        dlv_ack = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    msg_irq_decoder dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .xapic_en(xapic_en), .cap_req(cap_req),
        .edge_mask(edge_mask), .msg_cap(msg_cap), .irr(irr),
        .dlv_req(dlv_req), .dlv_vec(dlv_vec), .dlv_ack(dlv_ack)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic drain(input logic [23:0] exp_in);
        logic [23:0] e;
        e = exp_in;
        while (e != '0) begin
            int lo;
            lo = 0;
            for (int i = 23; i >= 0; i--) if (e[i]) lo = i;
            chk("R8 req", 32'(dlv_req), 32'd1);
            chk("R8 lowest vec", 32'(dlv_vec), 32'(lo));
            dlv_ack = 1'b1;
            @(negedge clk);
            dlv_ack = 1'b0;
            e[lo] = 1'b0;
            chk("R9 ack clear", 32'(irr), 32'(e));
        end
        chk("R8 idle", 32'(dlv_req), 32'd0);
    endtask

    task automatic run_all();
        logic [23:0] masks [3];
        logic [23:0] e;
        masks[0] = 24'hFF_FFFF; masks[1] = 24'h55_5555; masks[2] = 24'hAA_AAAA;

        repeat (3) @(negedge clk);
        chk("R12 reset irr", 32'(irr), 32'd0);
        chk("R12 reset cap", 32'(msg_cap), 32'd0);
        chk("R8 reset req", 32'(dlv_req), 32'd0);
        rst_n = 1'b1;

        // R6: capability needs the extended enable
        cap_req = 1'b1; xapic_en = 1'b0;
        @(negedge clk);
        chk("R6 cap without ext", 32'(msg_cap), 32'd0);
        wr(TGT, 32'd9);
        chk("R5 write while cap off", 32'(irr), 32'd0);
        cap_req = 1'b0; xapic_en = 1'b1;
        @(negedge clk);
        chk("R6 cap not requested", 32'(msg_cap), 32'd0);
        wr(TGT, 32'd9);
        chk("R5 write while cap off", 32'(irr), 32'd0);
        cap_req = 1'b1;
        @(negedge clk);
        chk("R6 cap on", 32'(msg_cap), 32'd1);

        // R2 R3 R4 R7: full sweep of the number field
        for (int m = 0; m < 3; m++) begin
            edge_mask = masks[m];
            for (int n = 0; n < 32; n++) begin
                logic [31:0] d;
                d = {27'(n * 32'h0135_79BD + m + 1), 5'(n)};
                wr(TGT, d);
                e = '0;
                if (n < 24 && !RES[n] && masks[m][n]) e[n] = 1'b1;
                if (n >= 24)           chk("R3 out of range", 32'(irr), 32'(e));
                else if (RES[n])       chk("R4 reserved line", 32'(irr), 32'(e));
                else if (!masks[m][n]) chk("R7 level line", 32'(irr), 32'(e));
                else                   chk("R2 decode", 32'(irr), 32'(e));
                drain(e);
            end
        end
        edge_mask = '1;

        // R1: address filter
        wr(TGT + 32'd4, 32'd5);
        chk("R1 near address", 32'(irr), 32'd0);
        wr(32'hFEC0_0000, 32'd5);
        chk("R1 base address", 32'(irr), 32'd0);
        wr(TGT ^ 32'h1000_0000, 32'd5);
        chk("R1 far address", 32'(irr), 32'd0);

        // R8: several pending, lowest first
        wr(TGT, 32'd20); wr(TGT, 32'd5); wr(TGT, 32'd3); wr(TGT, 32'd17);
        e = (24'd1 << 20) | (24'd1 << 5) | (24'd1 << 3) | (24'd1 << 17);
        chk("R8 multi pending", 32'(irr), 32'(e));
        drain(e);

        // R10: merge
        wr(TGT, 32'd9); wr(TGT, 32'h0000_0409);
        chk("R10 merged", 32'(irr), 32'(24'd1 << 9));
        drain(24'd1 << 9);

        // R11: set and clear of the same bit collide
        wr(TGT, 32'd6);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = TGT; wr_data = 32'd6; dlv_ack = 1'b1;
        @(negedge clk);
        wr_valid = 1'b0; dlv_ack = 1'b0;
        chk("R11 set wins", 32'(irr), 32'(24'd1 << 6));
        // different bits in the same cycle
        wr_valid = 1'b1; wr_addr = TGT; wr_data = 32'd11; dlv_ack = 1'b1;
        @(negedge clk);
        wr_valid = 1'b0; dlv_ack = 1'b0;
        chk("R9 clear with other set", 32'(irr), 32'(24'd1 << 11));

        // R12: reset in operation
        wr(TGT, 32'd22);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R12 reset irr", 32'(irr), 32'd0);
        chk("R12 reset cap", 32'(msg_cap), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog expired actual=running expected=done");
            end
        join_any
        disable fork;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule